// File: doc/BRIEF.md
# CPU Status Flag Register Unit

This block keeps the processor status byte of a CPU core that can run either in an 8-bit compatible mode or in a native 16-bit capable mode, together with the hidden emulation bit that picks between the two. Every clock edge it applies one command taken from a small command code. The commands cover arithmetic flag updates, set and clear under an immediate mask, a carry/emulation swap, a full-byte load for pull and interrupt return, trap and interrupt entry, the two bit-test forms and logical shift right.

The stored flags, the emulation bit and the two width selects come out as individual registered outputs. A separate packed byte is provided for pushes to the stack. While the emulation bit is set, the accumulator and index width selects are pinned at 8 bits. In the pushed byte of that mode, bit 5 reads as 1 and bit 4 carries the break source given by the caller.

Top module: `cpu_flag_reg`

## Requirements
- R1: After reset the emulation bit is 1 and the stored byte is 8'h34. Bit order from bit 7 to bit 0 is N, V, M, X, D, I, Z, C, so M, X and I are 1 and N, V, D, Z, C are 0.
- R2: `acc_8bit` follows stored bit 5 (M) and `idx_8bit` follows stored bit 4 (X). A value of 1 means 8-bit width and 0 means 16-bit width. In native mode a clear-mask of 8'h30 gives two 16-bit selects.
- R3: Command 1 (ALU update) writes N, V, Z and C from `alu_val[3:0]` = {N,V,Z,C}, but only where the matching bit of `alu_wr[3:0]` is 1. All other bits keep their value.
- R4: Command 2 (set mask) sets every stored bit whose bit in `arg` is 1 and leaves the rest unchanged.
- R5: Command 3 (clear mask) clears every stored bit whose bit in `arg` is 1 and leaves the rest unchanged.
- R6: While the emulation bit is 1, bits 5 and 4 stay 1. This holds through set, clear, load and every other command, so writes to those bits have no effect.
- R7: Command 4 (exchange) puts the old carry into the emulation bit and the old emulation bit into the carry in one edge. If the new emulation bit is 1, bits 5 and 4 are forced to 1 in that same edge.
- R8: Command 5 (load) writes all 8 bits from `arg` at once, with the forcing rule of R6 still applied.
- R9: Command 6 (software break or coprocessor trap) and command 7 (hardware interrupt entry) clear D and set I. All other bits are left as they were.
- R10: Command 8 (bit test) copies `arg[7]` into N and `arg[6]` into V, and Z from `alu_val[1]`. Command 9 (immediate bit test) changes only Z, taking it from `alu_val[1]`.
- R11: Command 10 (shift right) clears N and loads Z and C from `alu_val[1]` and `alu_val[0]`. V, D, I, M and X are unchanged.
- R12: In native mode `status_push` equals the stored byte. In emulation mode `status_push` has bit 5 at 1 and bit 4 equal to `push_brk` (1 for software break, 0 for hardware IRQ).
- R13: Command 0 and command codes 11 to 15 leave the stored byte and the emulation bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Command code applied at the next rising edge |
| arg | input | 8 | Mask, load byte or bit-test operand |
| alu_wr | input | 4 | Write enables for {N,V,Z,C} on ALU update |
| alu_val | input | 4 | Flag values {N,V,Z,C} from the ALU |
| push_brk | input | 1 | Break source placed in bit 4 of a pushed byte in emulation mode |
| status_push | output | 8 | Packed status byte for stack pushes |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_d | output | 1 | Decimal mode flag |
| flag_i | output | 1 | Interrupt disable flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| emu | output | 1 | Emulation bit |
| acc_8bit | output | 1 | Accumulator width select, 1 = 8 bits |
| idx_8bit | output | 1 | Index width select, 1 = 8 bits |

## Verification
Every command takes effect in the registered state at the first rising edge after it is presented, so the flags, the emulation bit and the width selects are due exactly one edge later. `status_push` is also combinational in `push_brk`, so within that same cycle it follows whatever value `push_brk` has. The bench drives each command just after a falling edge and computes the expected state from its own model. It queues that state, and the monitor pops and compares it a quarter period after the following rising edge, while the inputs are still held. The reset state is compared directly once reset has been released and before any command is issued.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;

   localparam int unsigned SB_W  = 8;
   localparam int unsigned CMD_W = 4;

   localparam int unsigned POS_C = 0;
   localparam int unsigned POS_Z = 1;
   localparam int unsigned POS_I = 2;
   localparam int unsigned POS_D = 3;
   localparam int unsigned POS_X = 4;
   localparam int unsigned POS_M = 5;
   localparam int unsigned POS_V = 6;
   localparam int unsigned POS_N = 7;

   localparam logic [SB_W-1:0] WIDTH_BITS = (SB_W'(1) << POS_M) | (SB_W'(1) << POS_X);

   typedef enum logic [CMD_W-1:0] {
      FC_IDLE   = 4'd0,
      FC_ALU    = 4'd1,
      FC_SET    = 4'd2,
      FC_CLR    = 4'd3,
      FC_XCE    = 4'd4,
      FC_LOAD   = 4'd5,
      FC_SWTRAP = 4'd6,
      FC_HWINT  = 4'd7,
      FC_BIT    = 4'd8,
      FC_BITI   = 4'd9,
      FC_LSR    = 4'd10
   } fcmd_e;

endpackage

// File: rtl/flagreg_next.sv
module flagreg_next
   import flagreg_pkg::*;
#(
   parameter bit HWINT_CLR_D = 1'b1
) (
   input  logic [CMD_W-1:0] cmd,
   input  logic [SB_W-1:0]  arg,
   input  logic [3:0]       alu_wr,
   input  logic [3:0]       alu_val,
   input  logic [SB_W-1:0]  cur_p,
   input  logic             cur_e,
   output logic [SB_W-1:0]  nxt_p,
   output logic             nxt_e
);

   logic hw_d;

   generate
      if (HWINT_CLR_D) begin : g_hw_clr
         assign hw_d = 1'b0;
      end else begin : g_hw_keep
         assign hw_d = cur_p[POS_D];
      end
   endgenerate

   always_comb begin
      nxt_p = cur_p;
      nxt_e = cur_e;
      unique case (fcmd_e'(cmd))
         FC_ALU: begin
            if (alu_wr[3]) nxt_p[POS_N] = alu_val[3];
            if (alu_wr[2]) nxt_p[POS_V] = alu_val[2];
            if (alu_wr[1]) nxt_p[POS_Z] = alu_val[1];
            if (alu_wr[0]) nxt_p[POS_C] = alu_val[0];
         end
         FC_SET:  nxt_p = cur_p | arg;
         FC_CLR:  nxt_p = cur_p & ~arg;
         FC_XCE: begin
            nxt_e        = cur_p[POS_C];
            nxt_p[POS_C] = cur_e;
         end
         FC_LOAD: nxt_p = arg;
         FC_SWTRAP: begin
            nxt_p[POS_D] = 1'b0;
            nxt_p[POS_I] = 1'b1;
         end
         FC_HWINT: begin
            nxt_p[POS_D] = hw_d;
            nxt_p[POS_I] = 1'b1;
         end
         FC_BIT: begin
            nxt_p[POS_N] = arg[7];
            nxt_p[POS_V] = arg[6];
            nxt_p[POS_Z] = alu_val[1];
         end
         FC_BITI: nxt_p[POS_Z] = alu_val[1];
         FC_LSR: begin
            nxt_p[POS_N] = 1'b0;
            nxt_p[POS_Z] = alu_val[1];
            nxt_p[POS_C] = alu_val[0];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/flagreg_force.sv
module flagreg_force
   import flagreg_pkg::*;
(
   input  logic            emu_in,
   input  logic [SB_W-1:0] raw_p,
   output logic [SB_W-1:0] held_p
);

   for (genvar b = 0; b < SB_W; b++) begin : g_bit
      if (WIDTH_BITS[b]) begin : g_pin
         assign held_p[b] = raw_p[b] | emu_in;
      end else begin : g_pass
         assign held_p[b] = raw_p[b];
      end
   end

endmodule

// File: rtl/flagreg_pack.sv
module flagreg_pack
   import flagreg_pkg::*;
(
   input  logic            emu_in,
   input  logic            brk_src,
   input  logic [SB_W-1:0] st_p,
   output logic [SB_W-1:0] push_p
);

   always_comb begin
      push_p = st_p;
      if (emu_in) begin
         push_p[POS_M] = 1'b1;
         push_p[POS_X] = brk_src;
      end
   end

endmodule

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg
   import flagreg_pkg::*;
#(
   parameter bit              RST_EMU     = 1'b1,
   parameter logic [SB_W-1:0] RST_BYTE    = 8'h34,
   parameter bit              HWINT_CLR_D = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd,
   input  logic [SB_W-1:0]  arg,
   input  logic [3:0]       alu_wr,
   input  logic [3:0]       alu_val,
   input  logic             push_brk,
   output logic [SB_W-1:0]  status_push,
   output logic             flag_n,
   output logic             flag_v,
   output logic             flag_d,
   output logic             flag_i,
   output logic             flag_z,
   output logic             flag_c,
   output logic             emu,
   output logic             acc_8bit,
   output logic             idx_8bit
);

   localparam logic [SB_W-1:0] RST_HELD = RST_EMU ? (RST_BYTE | WIDTH_BITS) : RST_BYTE;

   generate
      if (SB_W != 8) begin : g_bad_width
         $error("status byte must be 8 bits wide");
      end
      if (CMD_W < 4) begin : g_bad_cmd
         $error("command code needs at least 4 bits");
      end
   endgenerate

   logic [SB_W-1:0] p_q, p_raw, p_held;
   logic            e_q, e_nxt;

   flagreg_next #(.HWINT_CLR_D(HWINT_CLR_D)) u_next (
      .cmd    (cmd),
      .arg    (arg),
      .alu_wr (alu_wr),
      .alu_val(alu_val),
      .cur_p  (p_q),
      .cur_e  (e_q),
      .nxt_p  (p_raw),
      .nxt_e  (e_nxt)
   );

   flagreg_force u_force (
      .emu_in(e_nxt),
      .raw_p (p_raw),
      .held_p(p_held)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q <= RST_HELD;
         e_q <= RST_EMU;
      end else begin
         p_q <= p_held;
         e_q <= e_nxt;
      end
   end

   flagreg_pack u_pack (
      .emu_in (e_q),
      .brk_src(push_brk),
      .st_p   (p_q),
      .push_p (status_push)
   );

   assign flag_n   = p_q[POS_N];
   assign flag_v   = p_q[POS_V];
   assign acc_8bit = p_q[POS_M];
   assign idx_8bit = p_q[POS_X];
   assign flag_d   = p_q[POS_D];
   assign flag_i   = p_q[POS_I];
   assign flag_z   = p_q[POS_Z];
   assign flag_c   = p_q[POS_C];
   assign emu      = e_q;

endmodule

// File: rtl/flagreg_chk.sv
module flagreg_chk
   import flagreg_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [CMD_W-1:0] cmd,
   input logic [SB_W-1:0]  arg,
   input logic [3:0]       alu_wr,
   input logic [3:0]       alu_val,
   input logic             push_brk,
   input logic [SB_W-1:0]  status_push,
   input logic             flag_n,
   input logic             flag_v,
   input logic             flag_d,
   input logic             flag_i,
   input logic             flag_z,
   input logic             flag_c,
   input logic             emu,
   input logic             acc_8bit,
   input logic             idx_8bit
);

   logic [SB_W:0] st_all;
   assign st_all = {emu, flag_n, flag_v, acc_8bit, idx_8bit, flag_d, flag_i, flag_z, flag_c};

   AST_EMU_WIDTHS: assert property (@(posedge clk) disable iff (!rst_n)
      emu |-> (acc_8bit && idx_8bit)); // R6

   AST_XCE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == FC_XCE) |=> (emu == $past(flag_c)) && (flag_c == $past(emu))); // R7

   AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == FC_SWTRAP) |=> (!flag_d && flag_i)); // R9

   AST_LSR_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == FC_LSR) |=> !flag_n); // R11

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == FC_IDLE) || (cmd > FC_LSR)) |=> $stable(st_all)); // R13

   AST_PUSH_EMU: assert property (@(posedge clk) disable iff (!rst_n)
      emu |-> (status_push[POS_M] && (status_push[POS_X] == push_brk))); // R12

endmodule

bind cpu_flag_reg flagreg_chk u_chk (.*);

// File: tb/sim_cpu_flag_reg.sv
module sim_cpu_flag_reg;

   localparam int PER = 10;

   typedef struct {
      logic [7:0] p;
      logic       e;
      logic [7:0] push;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cmd = 4'd0;
   logic [7:0] arg = 8'h00;
   logic [3:0] alu_wr = 4'h0;
   logic [3:0] alu_val = 4'h0;
   logic       push_brk = 1'b0;
   logic [7:0] status_push;
   logic       flag_n, flag_v, flag_d, flag_i, flag_z, flag_c, emu, acc_8bit, idx_8bit;

   int checks = 0;
   int errors = 0;
   exp_t q[$];
   logic [7:0] mp;
   logic       me;
   bit         done = 1'b0;

   always #(PER/2) clk = ~clk;

   cpu_flag_reg u0 (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .arg(arg), .alu_wr(alu_wr),
      .alu_val(alu_val), .push_brk(push_brk), .status_push(status_push),
      .flag_n(flag_n), .flag_v(flag_v), .flag_d(flag_d), .flag_i(flag_i),
      .flag_z(flag_z), .flag_c(flag_c), .emu(emu), .acc_8bit(acc_8bit),
      .idx_8bit(idx_8bit)
   );

   function automatic logic [7:0] act_p();
      return {flag_n, flag_v, acc_8bit, idx_8bit, flag_d, flag_i, flag_z, flag_c};
   endfunction

   task automatic compare(input exp_t x);
      checks++;
      if (act_p() !== x.p || emu !== x.e || status_push !== x.push) begin
         errors++;
         $display("FAIL %s: p=%h e=%b push=%h expected p=%h e=%b push=%h",
                  x.tag, act_p(), emu, status_push, x.p, x.e, x.push);
      end
   endtask

   task automatic issue(input logic [3:0] c, input logic [7:0] a, input logic [3:0] w,
                        input logic [3:0] v, input logic brk, input string tag);
      exp_t x;
      @(negedge clk);
      cmd = c; arg = a; alu_wr = w; alu_val = v; push_brk = brk;
      case (c)
         4'd1: begin
            if (w[3]) mp[7] = v[3];
            if (w[2]) mp[6] = v[2];
            if (w[1]) mp[1] = v[1];
            if (w[0]) mp[0] = v[0];
         end
         4'd2: mp = mp | a;
         4'd3: mp = mp & ~a;
         4'd4: begin logic t; t = mp[0]; mp[0] = me; me = t; end
         4'd5: mp = a;
         4'd6, 4'd7: begin mp[3] = 1'b0; mp[2] = 1'b1; end
         4'd8: begin mp[7] = a[7]; mp[6] = a[6]; mp[1] = v[1]; end
         4'd9: mp[1] = v[1];
         4'd10: begin mp[7] = 1'b0; mp[1] = v[1]; mp[0] = v[0]; end
         default: ;
      endcase
      if (me) mp[5:4] = 2'b11;
      x.p = mp;
      x.e = me;
      x.push = me ? {mp[7:6], 1'b1, brk, mp[3:0]} : mp;
      x.tag = tag;
      q.push_back(x);
   endtask

   // monitor: results are due one rising edge after the command
   always @(posedge clk) begin
      #(PER/4);
      if (q.size() > 0) compare(q.pop_front());
   end

   initial begin
      #(PER * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      mp = 8'h34; me = 1'b1;
      r.p = 8'h34; r.e = 1'b1; r.push = {2'b00, 1'b1, 1'b0, 4'h4}; r.tag = "R1 reset";
      compare(r);

      issue(4'd2,  8'hFF, 4'h0, 4'h0, 1'b1, "R4 set all in emulation");
      issue(4'd3,  8'h30, 4'h0, 4'h0, 1'b0, "R6 clear widths ignored");
      issue(4'd3,  8'hCF, 4'h0, 4'h0, 1'b1, "R5 clear mask");
      issue(4'd5,  8'h00, 4'h0, 4'h0, 1'b0, "R8 R6 load zero in emulation");
      issue(4'd4,  8'h00, 4'h0, 4'h0, 1'b0, "R7 exchange to native");
      issue(4'd3,  8'h30, 4'h0, 4'h0, 1'b0, "R2 widths to 16");
      issue(4'd2,  8'h20, 4'h0, 4'h0, 1'b0, "R2 accumulator back to 8");
      issue(4'd5,  8'hA5, 4'h0, 4'h0, 1'b1, "R8 R12 native load and push");
      issue(4'd1,  8'h00, 4'b1010, 4'b0101, 1'b0, "R3 ALU N Z only");
      issue(4'd1,  8'hFF, 4'b0101, 4'b0101, 1'b0, "R3 ALU V C only");
      issue(4'd3,  8'h04, 4'h0, 4'h0, 1'b0, "R5 clear I");
      issue(4'd2,  8'h08, 4'h0, 4'h0, 1'b0, "R4 set D");
      issue(4'd6,  8'h00, 4'h0, 4'h0, 1'b0, "R9 software trap");
      issue(4'd3,  8'h04, 4'h0, 4'h0, 1'b0, "R5 clear I again");
      issue(4'd2,  8'h08, 4'h0, 4'h0, 1'b0, "R4 set D again");
      issue(4'd7,  8'h00, 4'h0, 4'h0, 1'b0, "R9 hardware interrupt");
      issue(4'd8,  8'h80, 4'h0, 4'b0010, 1'b0, "R10 bit test");
      issue(4'd9,  8'hC0, 4'h0, 4'b0000, 1'b0, "R10 immediate bit test");
      issue(4'd10, 8'h00, 4'h0, 4'b0011, 1'b0, "R11 shift right");
      issue(4'd15, 8'hFF, 4'hF, 4'hF, 1'b0, "R13 unused code");
      issue(4'd0,  8'hFF, 4'hF, 4'h0, 1'b0, "R13 idle");
      issue(4'd4,  8'h00, 4'h0, 4'h0, 1'b1, "R7 exchange to emulation");
      issue(4'd0,  8'h00, 4'h0, 4'h0, 1'b0, "R12 emulation push hw");
      issue(4'd3,  8'hFF, 4'h0, 4'h0, 1'b1, "R6 clear all in emulation");
      issue(4'd4,  8'h00, 4'h0, 4'h0, 1'b0, "R7 exchange with carry clear");
      issue(4'd1,  8'h00, 4'b0001, 4'b0001, 1'b0, "R3 set carry");
      issue(4'd4,  8'h00, 4'h0, 4'h0, 1'b1, "R7 back to emulation");
      issue(4'd0,  8'h00, 4'h0, 4'h0, 1'b1, "R12 emulation push brk");
      @(negedge clk);
      cmd = 4'd0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule